// File: doc/BRIEF.md
# Look-Up-Table Style Distributed RAM

This block is a small RAM that behaves like memory built from logic look-up tables. A write lands on the rising clock edge while the write enable is high. A read is purely combinational: the data output follows the read address with no clock latency. The block is meant for register files, small FIFOs and coefficient stores, where a fast asynchronous read is worth more than density.

Two build-time choices shape it. `DUAL` picks the port arrangement. With `DUAL=0` there is one address bus, used by both reads and writes. With `DUAL=1` a second, read-only address and data output are added, and writes still go to the first port's address. `ADDR_W` picks the organisation, and the word width follows from it: the block holds 128 bits when single-ported and 64 bits when dual-ported. An optional output register (`OUT_REG=1`) samples each combinational read on the same clock as the write, which gives a synchronous read.

Top module: `dram_lut`

## Requirements
- R1: The word at `addr_a` takes `din` on a rising edge of `clk` only when `we` is 1. With `we` at 0, no stored word changes.
- R2: `dout_a` equals the word stored at `addr_a`, combinationally, with no clock latency.
- R3: With `DUAL=1`, `dout_b` equals the word stored at `addr_b`, combinationally. The write address is always `addr_a`, never `addr_b`.
- R4: After a write edge, every read port whose address equals the written address shows the new data, before the next edge.
- R5: The word width is 128 / 2^`ADDR_W` when `DUAL=0` (`ADDR_W` 4 to 7, giving 16x8, 32x4, 64x2 or 128x1). It is 64 / 2^`ADDR_W` when `DUAL=1` (`ADDR_W` 4 to 6, giving 16x4, 32x2 or 64x1). Every bit of a word is stored.
- R6: With `OUT_REG=1`, on each rising edge after reset release, `q_a` and `q_b` load the combinational read values `dout_a` and `dout_b` as they were just before that edge. On a write to the read address, this is the old word.
- R7: With `OUT_REG=0`, `q_a` and `q_b` stay at 0.
- R8: While `rst_n` is 0, `q_a` and `q_b` are 0. The release of `rst_n` is synchronised through two flops. Reset leaves the stored words untouched, and writes still land during reset.
- R9: With `DUAL=0`, `addr_b` is ignored, and `dout_b` and `q_b` stay at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for writes and the output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| we | input | 1 | Write enable, active high |
| addr_a | input | ADDR_W | Read/write address of port A |
| din | input | DATA_W | Write data |
| addr_b | input | ADDR_W | Read-only address of port B (dual-port build) |
| dout_a | output | DATA_W | Combinational read data of port A |
| dout_b | output | DATA_W | Combinational read data of port B, 0 in the single-port build |
| q_a | output | DATA_W | Registered read data of port A |
| q_b | output | DATA_W | Registered read data of port B |

## Verification
The bench aims at the write-through case: port A writes while port B reads the same address, and port A is read straight after its own write. A design that registered the read or decoded the write from the wrong address would show stale data on one of the ports. It also checks that the output register captures the old word on a colliding write; a register fed from the write data instead would show the new word one cycle early. A single-port 128x1 build runs beside the dual-port 32x2 build, to show that `addr_b` is ignored there and that the unregistered outputs stay at zero. Reset is asserted again in the middle of the run, to prove the stored words survive it.

// File: rtl/dram_pkg.sv
package dram_pkg;
  localparam int SP_BITS = 128;
  localparam int DP_BITS = 64;

  function automatic int data_width(input bit dual, input int aw);
    return (dual ? DP_BITS : SP_BITS) >> aw;
  endfunction
endpackage

// File: rtl/dram_rst_sync.sv
module dram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_ok = sync_q[1];
endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
  parameter int AW   = 5,
  parameter int DW   = 2,
  parameter bit DUAL = 1'b1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr_a,
  input  logic [AW-1:0] rd_addr_b,
  output logic [DW-1:0] rd_data_a,
  output logic [DW-1:0] rd_data_b
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] word_q [DEPTH];
  logic [DEPTH-1:0] word_en;

  // one-hot write strobe per word
  always_comb begin
    word_en = '0;
    if (we) word_en[wr_addr] = 1'b1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (word_en[i]) word_q[i] <= wr_data;
    end
  end

  assign rd_data_a = word_q[rd_addr_a];

  if (DUAL) begin : g_port_b
    assign rd_data_b = word_q[rd_addr_b];
  end else begin : g_no_port_b
    assign rd_data_b = '0;
  end
endmodule

// File: rtl/dram_out_reg.sv
module dram_out_reg #(
  parameter int DW = 2
) (
  input  logic          clk,
  input  logic          rst_ok,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_nxt;

  always_comb q_nxt = d;

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) q <= '0;
    else         q <= q_nxt;
  end
endmodule

// File: rtl/dram_lut.sv
module dram_lut #(
  parameter bit DUAL    = 1'b1,
  parameter int ADDR_W  = 5,
  parameter bit OUT_REG = 1'b1,
  localparam int DATA_W = dram_pkg::data_width(DUAL, ADDR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [DATA_W-1:0] din,
  input  logic [ADDR_W-1:0] addr_b,
  output logic [DATA_W-1:0] dout_a,
  output logic [DATA_W-1:0] dout_b,
  output logic [DATA_W-1:0] q_a,
  output logic [DATA_W-1:0] q_b
);
  logic rst_ok;

  dram_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  dram_cell_array #(.AW(ADDR_W), .DW(DATA_W), .DUAL(DUAL)) u_cells (
    .clk       (clk),
    .we        (we),
    .wr_addr   (addr_a),
    .wr_data   (din),
    .rd_addr_a (addr_a),
    .rd_addr_b (addr_b),
    .rd_data_a (dout_a),
    .rd_data_b (dout_b)
  );

  if (OUT_REG) begin : g_oreg
    dram_out_reg #(.DW(DATA_W)) u_qa (
      .clk (clk), .rst_ok (rst_ok), .d (dout_a), .q (q_a)
    );
    if (DUAL) begin : g_oreg_b
      dram_out_reg #(.DW(DATA_W)) u_qb (
        .clk (clk), .rst_ok (rst_ok), .d (dout_b), .q (q_b)
      );
    end else begin : g_no_oreg_b
      assign q_b = '0;
    end
  end else begin : g_no_oreg
    assign q_a = '0;
    assign q_b = '0;
  end
endmodule

// File: rtl/dram_lut_chk.sv
module dram_lut_chk #(
  parameter bit DUAL    = 1'b1,
  parameter int AW      = 5,
  parameter bit OUT_REG = 1'b1,
  parameter int DW      = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rst_ok,
  input logic          we,
  input logic [AW-1:0] addr_a,
  input logic [DW-1:0] din,
  input logic [AW-1:0] addr_b,
  input logic [DW-1:0] dout_a,
  input logic [DW-1:0] dout_b,
  input logic [DW-1:0] q_a,
  input logic [DW-1:0] q_b
);
  // R4
  wr_thru_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (addr_a != $past(addr_a)) || (dout_a == $past(din)));

  // R1
  hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> (addr_a != $past(addr_a)) || (dout_a == $past(dout_a)));

  if (DUAL) begin : g_dual
    // R3
    wr_thru_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (addr_b != $past(addr_a)) || (dout_b == $past(din)));
    // R3
    hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> (addr_b != $past(addr_b)) || (dout_b == $past(dout_b)));
  end else begin : g_single
    // R9
    quiet_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_b == '0) && (q_b == '0));
  end

  if (OUT_REG) begin : g_reg
    // R6
    reg_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_ok |=> q_a == $past(dout_a));
    // R6
    reg_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_ok |=> q_b == $past(dout_b));
  end else begin : g_noreg
    // R7
    q_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_a == '0) && (q_b == '0));
  end
endmodule

bind dram_lut dram_lut_chk #(
  .DUAL(DUAL), .AW(ADDR_W), .OUT_REG(OUT_REG), .DW(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_ok(rst_ok), .we(we),
  .addr_a(addr_a), .din(din), .addr_b(addr_b),
  .dout_a(dout_a), .dout_b(dout_b), .q_a(q_a), .q_b(q_b)
);

// File: tb/sim_dram_lut.sv
`timescale 1ns/1ps
module sim_dram_lut;
  localparam int AW0 = 5;
  localparam int DW0 = dram_pkg::data_width(1'b1, AW0);
  localparam int AW1 = 7;
  localparam int DW1 = dram_pkg::data_width(1'b0, AW1);

  logic clk = 1'b0;
  logic rst_n;
  logic we0, we1;
  logic [AW0-1:0] a0, b0;
  logic [DW0-1:0] d0, da0, db0, qa0, qb0;
  logic [AW1-1:0] a1, b1;
  logic [DW1-1:0] d1, da1, db1, qa1, qb1;

  int total = 0;
  int bad = 0;
  logic [DW0-1:0] sb0 [1<<AW0];
  logic [DW1-1:0] sb1 [1<<AW1];
  bit in_rst;

  always #10 clk = ~clk;

  dram_lut #(.DUAL(1'b1), .ADDR_W(AW0), .OUT_REG(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .we(we0), .addr_a(a0), .din(d0), .addr_b(b0),
    .dout_a(da0), .dout_b(db0), .q_a(qa0), .q_b(qb0));

  dram_lut #(.DUAL(1'b0), .ADDR_W(AW1), .OUT_REG(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .we(we1), .addr_a(a1), .din(d1), .addr_b(b1),
    .dout_a(da1), .dout_b(db1), .q_a(qa1), .q_b(qb1));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one clock of stimulus on both builds, with all checks
  task automatic op(input bit w0, input int ia0, input int id0, input int ib0,
                    input bit w1, input int ia1, input int id1, input int ib1);
    logic [DW0-1:0] xqa, xqb;
    @(negedge clk);
    we0 = w0; a0 = ia0[AW0-1:0]; d0 = id0[DW0-1:0]; b0 = ib0[AW0-1:0];
    we1 = w1; a1 = ia1[AW1-1:0]; d1 = id1[DW1-1:0]; b1 = ib1[AW1-1:0];
    #2;
    chk(da0 == sb0[a0], "R2 dual dout_a", da0, sb0[a0]);
    chk(db0 == sb0[b0], "R3 dout_b", db0, sb0[b0]);
    chk(da1 == sb1[a1], "R2 single dout_a", da1, sb1[a1]);
    chk(db1 == '0, "R9 single dout_b", db1, 0);
    xqa = in_rst ? '0 : sb0[a0];
    xqb = in_rst ? '0 : sb0[b0];
    @(posedge clk);
    if (we0) sb0[a0] = d0;
    if (we1) sb1[a1] = d1;
    #2;
    chk(qa0 == xqa, in_rst ? "R8 q_a in reset" : "R6 q_a", qa0, xqa);
    chk(qb0 == xqb, in_rst ? "R8 q_b in reset" : "R6 q_b", qb0, xqb);
    chk(qa1 == '0 && qb1 == '0, "R7 R9 single q", {qa1, qb1}, 0);
    chk(da0 == sb0[a0], "R4 R1 dout_a after edge", da0, sb0[a0]);
    chk(db0 == sb0[b0], "R4 R3 dout_b after edge", db0, sb0[b0]);
    chk(da1 == sb1[a1], "R4 R1 single after edge", da1, sb1[a1]);
  endtask

  initial begin
    #(20ns * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_2024));
    rst_n = 1'b0; in_rst = 1'b1;
    we0 = 0; a0 = 0; d0 = 0; b0 = 0;
    we1 = 0; a1 = 0; d1 = 0; b1 = 0;
    repeat (2) @(posedge clk);
    #2;
    chk(qa0 == '0 && qb0 == '0, "R8 reset state", {qa0, qb0}, 0);

    // R8 pre-write every word while reset is held
    for (int i = 0; i < (1 << AW1); i++) begin
      @(negedge clk);
      we0 = 1; a0 = i[AW0-1:0]; d0 = DW0'($urandom);
      we1 = 1; a1 = i[AW1-1:0]; d1 = DW1'($urandom);
      @(posedge clk);
      sb0[a0] = d0; sb1[a1] = d1;
    end
    op(0, 3, 0, 3, 0, 5, 0, 9);

    @(negedge clk); we0 = 0; we1 = 0; rst_n = 1'b1;
    repeat (3) @(posedge clk);
    in_rst = 1'b0;

    // R2 R3 sweep every address with no write
    for (int i = 0; i < (1 << AW0); i++) op(0, i, 0, (1 << AW0) - 1 - i, 0, i, 0, i + 1);

    // R4 write while port B reads the same address; R6 old word registered
    op(1, 7, 2'b11, 7, 1, 100, 1, 3);
    op(1, 7, 2'b10, 7, 1, 100, 0, 3);
    op(0, 7, 2'b01, 7, 0, 100, 1, 3);
    // R1 write enable low: din on the bus must not land
    op(0, 12, 2'b01, 12, 0, 127, ~sb1[127], 0);
    // R3 writes follow addr_a, not addr_b
    op(1, 0, 2'b11, 31, 1, 0, 1, 127);
    op(1, 31, 2'b00, 0, 1, 127, 0, 0);
    // R5 every bit of a full-width word is held
    op(1, 20, 2'b10, 20, 1, 64, 1, 64);
    op(1, 21, 2'b01, 20, 0, 64, 0, 64);
    op(0, 21, 0, 20, 0, 64, 0, 64);

    for (int n = 0; n < 3000; n++) begin
      int ra = $urandom_range((1 << AW0) - 1);
      bit hit = ($urandom_range(3) == 0);
      op($urandom_range(1), ra, $urandom, hit ? ra : $urandom_range((1 << AW0) - 1),
         $urandom_range(1), $urandom_range((1 << AW1) - 1), $urandom, $urandom);
    end

    // R8 reset again mid-run: q clears, words survive
    @(negedge clk); rst_n = 1'b0; in_rst = 1'b1;
    #2;
    chk(qa0 == '0 && qb0 == '0, "R8 async clear", {qa0, qb0}, 0);
    for (int i = 0; i < 8; i++) op(0, i, 0, i + 8, 0, i * 9, 0, i);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule